// File: doc/BRIEF.md
# Programmable pulse generator timer

The block is a free-running up-counter with two compare values that together shape a repeating rectangular wave. The period value sets the count at which the counter returns to zero. The width value sets a point inside the period. A single output flip-flop inverts each time the counter reaches either value. Software can force that flip-flop high or low at any time, and an enable bit decides whether the flip-flop reaches the output pin.

In use, software stops the counter, writes the period and width values, presets the flip-flop high and turns the output on. It then raises the count enable. Each period then lasts period + 1 clocks and starts with width + 1 clocks at the high level. The wave repeats without end. The compare values are written into holding registers. While the counter runs, the holding registers reach the comparators only when the counter clears, so a mid-period change never produces a short or long pulse.

Top module: `ppg_timer`

## Requirements
- R1: After reset the flip-flop is low, the output enable is off, the counter is zero and both compare values are zero. The pin is 0 even after the output is enabled, until a preset or a compare match changes the flip-flop.
- R2: While cnt_en is 1 the counter adds one per clock, and on the clock where it equals the active period value it goes to zero instead. While cnt_en is 0 the counter and the flip-flop hold their values.
- R3: For period value P (with width W < P), the output wave repeats every P + 1 enabled clocks.
- R4: After a high preset with the counter at zero, the pin is high exactly while the counter is in 0..W, which is W + 1 clocks of each period.
- R5: The flip-flop inverts on the clock after the counter equals the active period value, and also on the clock after it equals the active width value. Both inversions require cnt_en = 1.
- R6: A control write with ctl_wdata bit 1 set forces the flip-flop high, and one with bit 2 set forces it low. The change is seen on the next clock. A preset overrides a compare inversion in the same clock, and bit 1 wins when both bits are set.
- R7: The output enable is ctl_wdata bit 0, stored on every control write. While it is 0 the pin is 0, but the flip-flop keeps its state and keeps toggling.
- R8: Period and width writes go to holding registers. While counting, these move to the active compare values only on the clock where the counter clears. While cnt_en is 0 they move on every clock.
- R9: The wave repeats across consecutive periods with no one-shot stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter advance enable |
| per_we | input | 1 | Period holding register write strobe |
| per_wdata | input | CNT_W | Period value (P) |
| wid_we | input | 1 | Width holding register write strobe |
| wid_wdata | input | CNT_W | Width value (W) |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Bit 0 output enable, bit 1 preset high, bit 2 preset low |
| pwm_o | output | 1 | Pulse output pin |

## Verification
A software preset and a compare inversion can fall in the same clock, and so can a compare-value write and the counter's clear. The bench provokes the first by issuing a high preset exactly when the counter sits on the width value. There the inversion alone would drive the pin low, so a high pin on the next clock shows that the preset won. Next comes a write with both preset bits set, on a clock with no match. For the second, new compare values are written mid-period. The old period must finish intact, and the new shape must start exactly at the next zero of the counter. All of this is judged against the pin pattern computed from period and width in the bench.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  // control word bit positions
  localparam int CTL_OUT_EN = 0;
  localparam int CTL_SET_HI = 1;
  localparam int CTL_SET_LO = 2;
  localparam int CTL_W      = 3;

  // next counter value: wrap to zero on reaching the period value
  function automatic logic [31:0] ppg_next_count(input logic [31:0] cur,
                                                 input logic [31:0] top);
    if (cur == top) return 32'd0;
    return cur + 32'd1;
  endfunction

  // resolved flip-flop update: presets beat the toggle, high beats low
  function automatic logic ppg_ff_next(input logic cur, input logic tgl,
                                       input logic set_hi, input logic set_lo);
    if (set_hi) return 1'b1;
    if (set_lo) return 1'b0;
    if (tgl) return ~cur;
    return cur;
  endfunction
endpackage

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  import ppg_pkg::*;

  logic [31:0] nxt_wide;

  assign wrap     = en && (cnt == top);
  assign nxt_wide = ppg_next_count(32'(cnt), 32'(top));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= nxt_wide[CNT_W-1:0];
  end

  // R2: clear after a period match
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R2: single step otherwise
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> cnt == $past(cnt) + 1'b1);
  // R2: hold while disabled
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/ppg_compare.sv
module ppg_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             wid_we,
  input  logic [CNT_W-1:0] wid_wdata,
  output logic [CNT_W-1:0] per_act,
  output logic             hit_per,
  output logic             hit_wid
);
  logic [CNT_W-1:0] per_hold, wid_hold, wid_act;
  logic             load_act;

  assign load_act = !en || wrap;
  assign hit_per  = en && (cnt == per_act);
  assign hit_wid  = en && (cnt == wid_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_hold <= '0;
      wid_hold <= '0;
    end else begin
      if (per_we) per_hold <= per_wdata;
      if (wid_we) wid_hold <= wid_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act <= '0;
      wid_act <= '0;
    end else if (load_act) begin
      per_act <= per_hold;
      wid_act <= wid_hold;
    end
  end

  // R8: active values never move inside a running period
  a_r8_no_midperiod_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(per_act) && $stable(wid_act)));
  // R8: a running clear takes the holding value
  a_r8_load_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> per_act == $past(per_hold));
endmodule

// File: rtl/ppg_outff.sv
module ppg_outff (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl,
  input  logic set_hi,
  input  logic set_lo,
  output logic ff
);
  import ppg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= 1'b0;
    else ff <= ppg_ff_next(ff, tgl, set_hi, set_lo);
  end

  // R6: high preset wins over everything
  a_r6_set_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_hi |=> ff);
  // R6: low preset when high is absent
  a_r6_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lo && !set_hi) |=> !ff);
  // R5: inversion on a match without preset
  a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl && !set_hi && !set_lo) |=> ff != $past(ff));
  // R5: no change without a match or preset
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgl && !set_hi && !set_lo) |=> $stable(ff));
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             wid_we,
  input  logic [CNT_W-1:0] wid_wdata,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_wdata,
  output logic             pwm_o
);
  import ppg_pkg::*;

  logic [CNT_W-1:0] cnt, per_act;
  logic             wrap, hit_per, hit_wid, toggle_evt;
  logic             set_hi_evt, set_lo_evt, ff, out_en;

  assign set_hi_evt = ctl_we && ctl_wdata[CTL_SET_HI];
  assign set_lo_evt = ctl_we && ctl_wdata[CTL_SET_LO];
  assign toggle_evt = hit_per || hit_wid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_en <= 1'b0;
    else if (ctl_we) out_en <= ctl_wdata[CTL_OUT_EN];
  end

  ppg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .top(per_act),
    .cnt(cnt), .wrap(wrap)
  );

  ppg_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .wrap(wrap), .cnt(cnt),
    .per_we(per_we), .per_wdata(per_wdata),
    .wid_we(wid_we), .wid_wdata(wid_wdata),
    .per_act(per_act), .hit_per(hit_per), .hit_wid(hit_wid)
  );

  ppg_outff u_ff (
    .clk(clk), .rst_n(rst_n), .tgl(toggle_evt),
    .set_hi(set_hi_evt), .set_lo(set_lo_evt), .ff(ff)
  );

  assign pwm_o = out_en && ff;

  // R7: pin is quiet when the output is off
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !pwm_o);
  // R5: the period match and the counter clear coincide
  a_r5_match_is_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hit_per |-> wrap);
  // R1: after reset the flip-flop starts low
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> !ff);
endmodule

// File: tb/ppg_timer_tb.sv
module ppg_timer_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic per_we = 1'b0, wid_we = 1'b0, ctl_we = 1'b0;
  logic [CNT_W-1:0] per_wdata = '0, wid_wdata = '0;
  logic [2:0] ctl_wdata = '0;
  logic pwm_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  ppg_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .per_we(per_we), .per_wdata(per_wdata),
    .wid_we(wid_we), .wid_wdata(wid_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .pwm_o(pwm_o)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: pwm_o=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    per_we = 1'b0; wid_we = 1'b0; ctl_we = 1'b0;
  endtask

  task automatic do_reset();
    cnt_en = 1'b0;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic setup(input int p, input int w, input logic [2:0] ctl);
    per_we = 1'b1; per_wdata = CNT_W'(p);
    wid_we = 1'b1; wid_wdata = CNT_W'(w);
    step();
    ctl_we = 1'b1; ctl_wdata = ctl;
    step();
    step();
  endtask

  function automatic logic pat(input int k, input int p, input int w);
    return ((k % (p + 1)) <= w);
  endfunction

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL watchdog: run did not end");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: pin low after reset and after enabling the output
    chk("R1 reset pin", pwm_o, 1'b0);
    ctl_we = 1'b1; ctl_wdata = 3'b001;
    step();
    chk("R1 ff low after reset", pwm_o, 1'b0);
    cnt_en = 1'b1;
    step();
    // active period 0: every clock is a period match, so the ff inverts
    chk("R1 zero period toggles", pwm_o, 1'b1);
    cnt_en = 1'b0;

    // R3 R4 R9: sweep of period and width
    for (int p = 1; p <= 6; p++) begin
      for (int w = 0; w < p; w++) begin
        do_reset();
        setup(p, w, 3'b011);
        cnt_en = 1'b1;
        for (int k = 0; k <= 3 * (p + 1); k++) begin
          chk($sformatf("R3 R4 R9 p=%0d w=%0d k=%0d", p, w, k), pwm_o, pat(k, p, w));
          step();
        end
      end
    end

    // R2: pause on the width-match count; no toggle, no advance
    do_reset();
    setup(4, 1, 3'b011);
    cnt_en = 1'b1;
    chk("R2 k0", pwm_o, 1'b1);
    step();
    chk("R2 k1", pwm_o, 1'b1);
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 hold while stopped", pwm_o, 1'b1);
    end
    cnt_en = 1'b1;
    for (int k = 1; k <= 11; k++) begin
      chk($sformatf("R2 resume k=%0d", k), pwm_o, pat(k, 4, 1));
      step();
    end

    // R6 R5: preset on the width-match clock, both bits, low preset
    do_reset();
    setup(5, 2, 3'b011);
    cnt_en = 1'b1;
    step();
    step();
    chk("R5 k2 before match", pwm_o, 1'b1);
    ctl_we = 1'b1; ctl_wdata = 3'b011;
    step();
    chk("R6 preset beats toggle k3", pwm_o, 1'b1);
    step();
    chk("R6 k4", pwm_o, 1'b1);
    step();
    chk("R6 k5", pwm_o, 1'b1);
    step();
    chk("R5 period match inverts k6", pwm_o, 1'b0);
    ctl_we = 1'b1; ctl_wdata = 3'b111;
    step();
    chk("R6 both bits high wins", pwm_o, 1'b1);
    ctl_we = 1'b1; ctl_wdata = 3'b101;
    step();
    chk("R6 low preset", pwm_o, 1'b0);
    // R7: output off while ff goes high at width match
    ctl_we = 1'b1; ctl_wdata = 3'b000;
    step();
    chk("R7 disabled pin k9", pwm_o, 1'b0);
    step();
    chk("R7 disabled pin k10", pwm_o, 1'b0);
    ctl_we = 1'b1; ctl_wdata = 3'b001;
    step();
    chk("R7 ff kept toggling k11", pwm_o, 1'b1);
    step();
    chk("R5 period match k12", pwm_o, 1'b0);

    // R8: mid-period write lands at the next clear
    do_reset();
    setup(5, 2, 3'b011);
    cnt_en = 1'b1;
    chk("R8 k0", pwm_o, 1'b1);
    step();
    per_we = 1'b1; per_wdata = CNT_W'(3);
    wid_we = 1'b1; wid_wdata = CNT_W'(0);
    chk("R8 k1", pwm_o, 1'b1);
    step();
    for (int k = 2; k <= 17; k++) begin
      chk($sformatf("R8 k=%0d", k), pwm_o,
          (k < 6) ? pat(k, 5, 2) : pat(k - 6, 3, 0));
      step();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule